// File: doc/BRIEF.md
# Three-Table Hash Insertion Engine with Entry Relocation

This block adds one key to a forwarding structure made of three hash tables. Each table has a row chosen by its own hash of the key, and every row holds a fixed number of ways. The engine keeps a fill count for every row. It can therefore tell which of the three candidate rows has room, and which is the least filled, without reading the tables. A new key goes into the least filled of its candidate rows that still has room.

When all three candidate rows are full, the engine does not give up at once. It reads one full row and takes out the entry at a way chosen by a rotating pointer. It writes the homeless key into that way. The removed entry then becomes the key to place, and the search repeats with that entry's own three candidate rows. This relocation has a cap on the number of moves. When the cap is reached, the key that is still homeless is written to an overflow store. If the overflow store is already full when a new key finds no room, the insertion ends with an error and nothing is written.

The table memories sit outside the block. The engine drives a synchronous read port that returns a whole row one cycle later, and a write port that writes one way. It accepts one request at a time and reports the outcome of each insertion with a done pulse.

Top module: `mhash_insert`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle until the insertion ends. A `req_valid` that is raised while `busy` is high is ignored, and the key it carries is never written.
- R2: For a key k, the candidate row in table t (t = 0, 1, 2) is k[t*ROW_W +: ROW_W] XOR k[3*ROW_W +: ROW_W]. The value on the table select ports is t.
- R3: If any candidate row holds fewer than WAYS entries, the key is written to way index = that row's current count. Ways fill from 0 upward. The row used is the least filled of the rows that have room, with ties going to the lowest table index. For a key that needs no relocation, `done` rises two cycles after the accepting edge, with `overflow` and `error` low.
- R4: If all three candidate rows are full and moves remain, the engine reads the candidate row of table P at way W. P is the table pointer and W is the way pointer, both zero after reset. One cycle later the engine writes the homeless key into that way, and the entry it displaced becomes the homeless key. After each such move, P steps 0→1→2→0 and W steps by one modulo WAYS. Both pointers keep their values from one insertion to the next.
- R5: After MAX_MOVES moves, if the homeless key still finds no free candidate row, it is written once to the overflow store port, and `done` is raised with `overflow` high.
- R6: If a newly requested key finds no free candidate row while the overflow store already holds VIC_DEPTH keys, `done` is raised with `error` high. In that case there is no table write and no overflow store write during that insertion.
- R7: `done` lasts one cycle, and `busy` is low in that cycle. `overflow` and `error` are high only together with `done`.
- R8: After reset, `busy`, `done`, `overflow` and `error` are low. Every row count and the overflow fill are zero, so the first key lands in table 0 at way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Insertion request |
| req_key | input | KEY_W | Key to insert |
| busy | output | 1 | Insertion in progress |
| done | output | 1 | One-cycle completion pulse |
| overflow | output | 1 | Completed insertion used the overflow store |
| error | output | 1 | Completed insertion failed because the overflow store is full |
| tbl_rd_en | output | 1 | Row read request |
| tbl_rd_sel | output | 2 | Table index for the read |
| tbl_rd_row | output | ROW_W | Row index for the read |
| tbl_rd_keys | input | WAYS*KEY_W | Row contents, one cycle after the read; way w at bits w*KEY_W |
| tbl_wr_en | output | 1 | Way write strobe |
| tbl_wr_sel | output | 2 | Table index for the write |
| tbl_wr_row | output | ROW_W | Row index for the write |
| tbl_wr_way | output | WAY_W | Way index for the write |
| tbl_wr_key | output | KEY_W | Key written |
| vic_wr_en | output | 1 | Overflow store write strobe |
| vic_wr_key | output | KEY_W | Key pushed into the overflow store |

## Verification
The first single key into empty tables separates the tie-break order and the way fill order, and it fixes the latency of a direct placement. A group of keys whose three hashes all point at row 0 fills those three rows quickly. It then drives the relocation chain until the move cap ends it in the overflow store, which exposes wrong pointer stepping or a wrong cap count. A long pseudo-random stream, checked against an independent model of the tables after every insertion, covers load balancing across rows, mixed relocations, overflow and finally the error path once the overflow store is full. A request pulsed during a busy insertion shows whether the handshake wrongly accepts it.

// File: rtl/mhash_pkg.sv
package mhash_pkg;
    localparam int NUM_TBL = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHOOSE = 2'd1,
        ST_READ   = 2'd2
    } ins_state_e;
endpackage

// File: rtl/mhash_rowgen.sv
module mhash_rowgen
    import mhash_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int ROW_W = 2
) (
    input  logic [KEY_W-1:0]                 key,
    output logic [NUM_TBL-1:0][ROW_W-1:0]    rows
);
    // The shared field is XORed with a different key field in each table
    for (genvar t = 0; t < NUM_TBL; t++) begin : g_hash
        assign rows[t] = key[t*ROW_W +: ROW_W] ^ key[NUM_TBL*ROW_W +: ROW_W];
    end
endmodule

// File: rtl/mhash_occ.sv
module mhash_occ
    import mhash_pkg::*;
#(
    parameter int ROW_W = 2,
    parameter int WAYS  = 2,
    parameter int CNT_W = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_TBL-1:0][ROW_W-1:0]    rows,
    input  logic                             inc_en,
    input  logic [1:0]                       inc_sel,
    input  logic [ROW_W-1:0]                 inc_row,
    output logic [NUM_TBL-1:0][CNT_W-1:0]    cnt
);
    localparam int ROWS = 1 << ROW_W;

    logic [CNT_W-1:0] occ_q [NUM_TBL][ROWS];
    logic [CNT_W-1:0] occ_d [NUM_TBL][ROWS];

    always_comb begin
        occ_d = occ_q;
        if (inc_en) begin
            occ_d[inc_sel][inc_row] = occ_q[inc_sel][inc_row] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TBL; t++) begin
                for (int r = 0; r < ROWS; r++) begin
                    occ_q[t][r] <= '0;
                end
            end
        end else begin
            occ_q <= occ_d;
        end
    end

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_rd
        assign cnt[t] = occ_q[t][rows[t]];
    end

    // R3: a placement never targets a row that is already full
    assert_no_row_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        inc_en |-> (occ_q[inc_sel][inc_row] < CNT_W'(WAYS)));
endmodule

// File: rtl/mhash_pick.sv
module mhash_pick
    import mhash_pkg::*;
#(
    parameter int WAYS  = 2,
    parameter int CNT_W = 2
) (
    input  logic [NUM_TBL-1:0][CNT_W-1:0] cnt,
    output logic                          any_free,
    output logic [1:0]                    sel
);
    always_comb begin
        any_free = 1'b0;
        sel      = 2'd0;
        // Strict less-than keeps the lowest table index on ties
        for (int t = 0; t < NUM_TBL; t++) begin
            if (cnt[t] < CNT_W'(WAYS)) begin
                if (!any_free || (cnt[t] < cnt[sel])) begin
                    sel = 2'(t);
                end
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mhash_insert.sv
module mhash_insert
    import mhash_pkg::*;
#(
    parameter int KEY_W     = 8,
    parameter int ROW_W     = 2,
    parameter int WAYS      = 2,
    parameter int MAX_MOVES = 4,
    parameter int VIC_DEPTH = 2,
    localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [KEY_W-1:0]         req_key,
    output logic                     busy,
    output logic                     done,
    output logic                     overflow,
    output logic                     error,
    output logic                     tbl_rd_en,
    output logic [1:0]               tbl_rd_sel,
    output logic [ROW_W-1:0]         tbl_rd_row,
    input  logic [WAYS*KEY_W-1:0]    tbl_rd_keys,
    output logic                     tbl_wr_en,
    output logic [1:0]               tbl_wr_sel,
    output logic [ROW_W-1:0]         tbl_wr_row,
    output logic [WAY_W-1:0]         tbl_wr_way,
    output logic [KEY_W-1:0]         tbl_wr_key,
    output logic                     vic_wr_en,
    output logic [KEY_W-1:0]         vic_wr_key
);
    localparam int CNT_W = $clog2(WAYS + 1);
    localparam int MV_W  = (MAX_MOVES < 1) ? 1 : $clog2(MAX_MOVES + 1);
    localparam int VC_W  = (VIC_DEPTH < 1) ? 1 : $clog2(VIC_DEPTH + 1);

    typedef struct packed {
        ins_state_e       st;
        logic [KEY_W-1:0] key;
        logic [MV_W-1:0]  moves;
        logic [1:0]       tbl_ptr;
        logic [WAY_W-1:0] way_ptr;
        logic [1:0]       ev_tbl;
        logic [ROW_W-1:0] ev_row;
        logic [WAY_W-1:0] ev_way;
        logic [VC_W-1:0]  vic_cnt;
        logic             done;
        logic             ovf;
        logic             err;
    } ins_reg_t;

    ins_reg_t s_q, s_d;

    logic [NUM_TBL-1:0][ROW_W-1:0] rows;
    logic [NUM_TBL-1:0][CNT_W-1:0] cnt;
    logic                          any_free;
    logic [1:0]                    pick;
    logic                          inc_en;

    mhash_rowgen #(.KEY_W(KEY_W), .ROW_W(ROW_W)) rowgen_i (
        .key  (s_q.key),
        .rows (rows)
    );

    mhash_occ #(.ROW_W(ROW_W), .WAYS(WAYS), .CNT_W(CNT_W)) occ_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rows    (rows),
        .inc_en  (inc_en),
        .inc_sel (pick),
        .inc_row (rows[pick]),
        .cnt     (cnt)
    );

    mhash_pick #(.WAYS(WAYS), .CNT_W(CNT_W)) pick_i (
        .cnt      (cnt),
        .any_free (any_free),
        .sel      (pick)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.ovf  = 1'b0;
        s_d.err  = 1'b0;

        inc_en     = 1'b0;
        tbl_rd_en  = 1'b0;
        tbl_rd_sel = s_q.tbl_ptr;
        tbl_rd_row = rows[s_q.tbl_ptr];
        tbl_wr_en  = 1'b0;
        tbl_wr_sel = pick;
        tbl_wr_row = rows[pick];
        tbl_wr_way = cnt[pick][WAY_W-1:0];
        tbl_wr_key = s_q.key;
        vic_wr_en  = 1'b0;
        vic_wr_key = s_q.key;

        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.key   = req_key;
                    s_d.moves = '0;
                    s_d.st    = ST_CHOOSE;
                end
            end
            ST_CHOOSE: begin
                if (any_free) begin
                    tbl_wr_en = 1'b1;
                    inc_en    = 1'b1;
                    s_d.done  = 1'b1;
                    s_d.st    = ST_IDLE;
                end else if (s_q.vic_cnt == VC_W'(VIC_DEPTH)) begin
                    // Only reachable for a fresh key: the fill is fixed during an insertion
                    s_d.err  = 1'b1;
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end else if (s_q.moves == MV_W'(MAX_MOVES)) begin
                    vic_wr_en   = 1'b1;
                    s_d.vic_cnt = s_q.vic_cnt + 1'b1;
                    s_d.ovf     = 1'b1;
                    s_d.done    = 1'b1;
                    s_d.st      = ST_IDLE;
                end else begin
                    tbl_rd_en   = 1'b1;
                    s_d.ev_tbl  = s_q.tbl_ptr;
                    s_d.ev_row  = rows[s_q.tbl_ptr];
                    s_d.ev_way  = s_q.way_ptr;
                    s_d.tbl_ptr = (s_q.tbl_ptr == 2'd2) ? 2'd0 : s_q.tbl_ptr + 2'd1;
                    s_d.way_ptr = (s_q.way_ptr == WAY_W'(WAYS - 1)) ? '0
                                                                     : s_q.way_ptr + 1'b1;
                    s_d.st      = ST_READ;
                end
            end
            ST_READ: begin
                tbl_wr_en  = 1'b1;
                tbl_wr_sel = s_q.ev_tbl;
                tbl_wr_row = s_q.ev_row;
                tbl_wr_way = s_q.ev_way;
                s_d.key    = tbl_rd_keys[s_q.ev_way*KEY_W +: KEY_W];
                s_d.moves  = s_q.moves + 1'b1;
                s_d.st     = ST_CHOOSE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.st != ST_IDLE);
    assign done     = s_q.done;
    assign overflow = s_q.ovf;
    assign error    = s_q.err;

    // R1: an accepted request makes the engine busy
    assert_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);
    // R7: completion is a single-cycle pulse while idle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_flags_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow || error) |-> done);
    // R3: the chosen row is no fuller than any other row with room
    for (genvar t = 0; t < NUM_TBL; t++) begin : g_least
        assert_least_loaded_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (any_free && (cnt[t] < CNT_W'(WAYS))) |-> (cnt[pick] <= cnt[t]));
    end
    // R4: every row read is followed by a replacement write to that row
    assert_read_then_swap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |=> (tbl_wr_en && (tbl_wr_sel == $past(tbl_rd_sel))
                       && (tbl_wr_row == $past(tbl_rd_row))));
    // R5: the move count stays inside the budget; a push to the store reports overflow
    assert_move_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.moves <= MV_W'(MAX_MOVES));
    assert_vic_reports_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vic_wr_en |=> (done && overflow));
    // R6: a failed insertion wrote nothing in its final cycle
    assert_error_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!$past(tbl_wr_en) && !$past(vic_wr_en)));
endmodule

// File: tb/mhash_insert_tb.sv
module mhash_insert_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int KEY_W      = 8;
    localparam int ROW_W      = 2;
    localparam int WAYS       = 2;
    localparam int MAX_MOVES  = 4;
    localparam int VIC_DEPTH  = 2;
    localparam int ROWS       = 1 << ROW_W;
    localparam int WAY_W      = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [KEY_W-1:0] req_key = '0;
    logic busy, done, overflow, error;
    logic tbl_rd_en, tbl_wr_en, vic_wr_en;
    logic [1:0] tbl_rd_sel, tbl_wr_sel;
    logic [ROW_W-1:0] tbl_rd_row, tbl_wr_row;
    logic [WAY_W-1:0] tbl_wr_way;
    logic [KEY_W-1:0] tbl_wr_key, vic_wr_key;
    logic [WAYS*KEY_W-1:0] tbl_rd_keys;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mhash_insert #(.KEY_W(KEY_W), .ROW_W(ROW_W), .WAYS(WAYS),
                   .MAX_MOVES(MAX_MOVES), .VIC_DEPTH(VIC_DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_key(req_key),
        .busy(busy), .done(done), .overflow(overflow), .error(error),
        .tbl_rd_en(tbl_rd_en), .tbl_rd_sel(tbl_rd_sel), .tbl_rd_row(tbl_rd_row),
        .tbl_rd_keys(tbl_rd_keys), .tbl_wr_en(tbl_wr_en), .tbl_wr_sel(tbl_wr_sel),
        .tbl_wr_row(tbl_wr_row), .tbl_wr_way(tbl_wr_way), .tbl_wr_key(tbl_wr_key),
        .vic_wr_en(vic_wr_en), .vic_wr_key(vic_wr_key)
    );

    // Table memories and overflow store attached to the engine's ports
    logic [KEY_W-1:0] dmem [3][ROWS][WAYS];
    logic [KEY_W-1:0] dvic [VIC_DEPTH+4];
    int dvic_n;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < 3; t++)
                for (int r = 0; r < ROWS; r++)
                    for (int w = 0; w < WAYS; w++) dmem[t][r][w] <= '0;
            for (int i = 0; i < VIC_DEPTH + 4; i++) dvic[i] <= '0;
            dvic_n <= 0;
            tbl_rd_keys <= '0;
        end else begin
            if (tbl_wr_en) dmem[tbl_wr_sel][tbl_wr_row][tbl_wr_way] <= tbl_wr_key;
            if (tbl_rd_en)
                for (int w = 0; w < WAYS; w++)
                    tbl_rd_keys[w*KEY_W +: KEY_W] <= dmem[tbl_rd_sel][tbl_rd_row][w];
            if (vic_wr_en) begin
                if (dvic_n < VIC_DEPTH + 4) dvic[dvic_n] <= vic_wr_key;
                dvic_n <= dvic_n + 1;
            end
        end
    end

    // Reference model built from the requirements
    logic [KEY_W-1:0] rmem [3][ROWS][WAYS];
    int rcnt [3][ROWS];
    logic [KEY_W-1:0] rvic [VIC_DEPTH];
    int rvic_n = 0;
    int rtp = 0;
    int rwp = 0;
    int r_moves_total = 0;
    int r_ovf_total = 0;
    int r_err_total = 0;

    function automatic int hrow(input logic [KEY_W-1:0] k, input int t);
        return int'(k[t*ROW_W +: ROW_W] ^ k[3*ROW_W +: ROW_W]);
    endfunction

    // returns 0 placed, 1 overflow, 2 error
    task automatic ref_insert(input logic [KEY_W-1:0] key, output int outcome);
        logic [KEY_W-1:0] cur;
        logic [KEY_W-1:0] occ;
        int mv;
        int best;
        int r;
        cur = key;
        mv = 0;
        outcome = -1;
        while (outcome < 0) begin
            best = -1;
            for (int t = 0; t < 3; t++) begin
                r = hrow(cur, t);
                if (rcnt[t][r] < WAYS)
                    if (best < 0 || rcnt[t][r] < rcnt[best][hrow(cur, best)]) best = t;
            end
            if (best >= 0) begin
                r = hrow(cur, best);
                rmem[best][r][rcnt[best][r]] = cur;
                rcnt[best][r]++;
                outcome = 0;
            end else if (rvic_n == VIC_DEPTH) begin
                outcome = 2;
            end else if (mv == MAX_MOVES) begin
                rvic[rvic_n] = cur;
                rvic_n++;
                outcome = 1;
            end else begin
                r = hrow(cur, rtp);
                occ = rmem[rtp][r][rwp];
                rmem[rtp][r][rwp] = cur;
                cur = occ;
                rtp = (rtp + 1) % 3;
                rwp = (rwp + 1) % WAYS;
                mv++;
                r_moves_total++;
            end
        end
        if (outcome == 1) r_ovf_total++;
        if (outcome == 2) r_err_total++;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cmp_tables(input string req);
        int bad;
        int a;
        int e;
        bad = 0;
        a = 0;
        e = 0;
        for (int t = 0; t < 3; t++)
            for (int r = 0; r < ROWS; r++)
                for (int w = 0; w < WAYS; w++)
                    if (dmem[t][r][w] !== rmem[t][r][w] && bad == 0) begin
                        bad = 1;
                        a = int'(dmem[t][r][w]);
                        e = int'(rmem[t][r][w]);
                    end
        check(bad == 0, req, "table contents", a, e);
        check(dvic_n == rvic_n, "R5", "overflow store fill", dvic_n, rvic_n);
        for (int i = 0; i < VIC_DEPTH; i++)
            if (i < rvic_n)
                check(dvic[i] == rvic[i], "R5", "overflow store key", int'(dvic[i]), int'(rvic[i]));
    endtask

    // Issue one insertion; optionally pulse a second request while busy
    task automatic do_insert(input logic [KEY_W-1:0] key, input bit spurious,
                             input logic [KEY_W-1:0] skey, output int cycles);
        int outcome;
        int to;
        to = 0;
        while (busy && to < 200) begin @(negedge clk); to++; end
        req_valid = 1'b1;
        req_key = key;
        @(negedge clk);
        cycles = 1;
        check(busy == 1'b1, "R1", "busy after accept", int'(busy), 1);
        if (spurious) begin
            req_key = skey;
        end else begin
            req_valid = 1'b0;
        end
        while (!done && cycles < 200) begin
            @(negedge clk);
            cycles++;
            req_valid = 1'b0;
        end
        ref_insert(key, outcome);
        if (cycles >= 200) begin
            check(1'b0, "R7", "insertion never completed", cycles, 0);
        end else begin
            check(busy == 1'b0, "R7", "busy in done cycle", int'(busy), 0);
            if (outcome == 2)
                check(error && !overflow, "R6", "error flag", int'({overflow, error}), 1);
            else if (outcome == 1)
                check(overflow && !error, "R5", "overflow flag", int'({overflow, error}), 2);
            else
                check(!overflow && !error, "R3", "clean placement flags", int'({overflow, error}), 0);
        end
        @(negedge clk);
        check(!done && !overflow && !error, "R7", "done single pulse",
              int'({done, overflow, error}), 0);
        cmp_tables("R4");
    endtask

    task automatic test_reset();
        check(!busy && !done && !overflow && !error, "R8", "outputs after reset",
              int'({busy, done, overflow, error}), 0);
    endtask

    task automatic test_first_key();
        int cyc;
        // 0x4B: rows 3^1=2 (t0), 2^1=3 (t1), 0^1=1 (t2); all counts zero -> table 0 way 0
        do_insert(8'h4B, 1'b0, '0, cyc);
        check(cyc == 2, "R3", "direct placement latency", cyc, 2);
        check(dmem[0][2][0] == 8'h4B, "R2", "row of table 0", int'(dmem[0][2][0]), 8'h4B);
        check(dmem[0][2][0] == 8'h4B, "R8", "first key at table 0 way 0", int'(dmem[0][2][0]), 8'h4B);
    endtask

    task automatic test_busy_ignore();
        int cyc;
        do_insert(8'h13, 1'b1, 8'hC6, cyc);
        repeat (2) @(negedge clk);
        check(!busy && !done, "R1", "request during busy not taken",
              int'({busy, done}), 0);
        cmp_tables("R1");
    endtask

    task automatic test_hot_row();
        int cyc;
        logic [KEY_W-1:0] hot [8];
        hot = '{8'h00, 8'h55, 8'hAA, 8'hFF, 8'h00, 8'h55, 8'hAA, 8'hFF};
        // every key here hashes to row 0 in all three tables
        for (int i = 0; i < 8; i++) do_insert(hot[i], 1'b0, '0, cyc);
        check(r_moves_total > 0, "R4", "relocation exercised", r_moves_total, 1);
        check(r_ovf_total > 0, "R5", "overflow exercised", r_ovf_total, 1);
    endtask

    task automatic test_stream();
        int cyc;
        logic [KEY_W-1:0] k;
        k = 8'h21;
        for (int i = 0; i < 40; i++) begin
            k = k * 8'd5 + 8'd3;
            do_insert(k, 1'b0, '0, cyc);
        end
        check(r_err_total > 0, "R6", "full overflow store reached", r_err_total, 1);
    endtask

    initial begin
        for (int t = 0; t < 3; t++)
            for (int r = 0; r < ROWS; r++) begin
                rcnt[t][r] = 0;
                for (int w = 0; w < WAYS; w++) rmem[t][r][w] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_first_key();
        test_busy_ignore();
        test_hot_row();
        test_stream();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule